// File: doc/BRIEF.md
# Over-Temperature Alarm with Hysteresis

This block watches a stream of 9-bit temperature samples and drives a single over-temperature alarm pin. Each sample arrives with a one-cycle valid strobe. Every sample is compared, as a signed two's-complement value in half-degree steps, against two programmable thresholds: an upper trip limit and a lower hysteresis limit. Before the alarm can fire, a programmable run of consecutive samples above the trip limit is required. This fault queue filters out single noisy conversions.

There are two alarm behaviours. In comparator mode the pin follows the temperature with hysteresis: it asserts on a trip and releases once a sample falls below the hysteresis limit. In interrupt mode the pin latches on a trip and releases only when the temperature register is read, which the bus side signals with a one-cycle strobe. After that read the alarm stays quiet, whatever the temperature does, until a sample has fallen below the hysteresis limit. This re-arms it.

The pin polarity is selectable. A mask input forces the pin to its inactive level without losing the alarm state. A stop input freezes monitoring, so incoming samples are ignored. The ADC, the sensor front end and the register interface sit outside the block, and they supply the limits and control bits as plain inputs.

Top module: `ovt_alarm`

## Requirements
- R1: A sample counts as hot when its signed 9-bit value is strictly greater than the trip limit (equal is not hot). A sample counts as cool when it is strictly less than the hysteresis limit. Both comparisons are signed, so 0x00A (+5 °C) is above 0x1EC (-10 °C).
- R2: The fault selector sets how many consecutive hot samples trip the alarm: 0 needs 1 sample, 1 needs 2, 2 needs 4 and 3 needs 6. Any valid sample that is not hot restarts the count.
- R3: In comparator mode (mode input 0), an asserted alarm stays asserted through samples at or above the hysteresis limit and through temperature reads. It releases on the first valid cool sample.
- R4: In interrupt mode (mode input 1), an asserted alarm stays asserted through cool samples. It releases in the cycle after a temperature-read strobe.
- R5: After an interrupt-mode release, hot samples do not assert the alarm again until one valid cool sample has been seen. After that, a new hot run trips it as usual.
- R6: With the polarity input at 1 the pin is high while the alarm is active and low otherwise. With the polarity input at 0 the levels are inverted.
- R7: While the mask input is 1 the pin sits at its inactive level. Clearing the mask shows the alarm state that was held meanwhile.
- R8: While the stop input is 1, valid samples change neither the hot-run count nor the alarm state.
- R9: Temperature values presented without the valid strobe have no effect.
- R10: After reset the alarm is inactive and the hot-run count is zero.
- R11: A temperature read while no alarm is latched has no effect. A read in the same cycle as a cool sample releases a latched alarm into the waiting state, and that cool sample does not count for re-arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Sample strobe, one cycle per conversion |
| samp_temp | input | 9 | Temperature sample, signed, 0.5 °C per LSB |
| lim_over | input | 9 | Trip limit, signed |
| lim_hyst | input | 9 | Hysteresis limit, signed |
| fault_sel | input | 2 | Consecutive-hot-sample selector |
| irq_mode | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| act_high | input | 1 | 1 = pin active high, 0 = active low |
| stop | input | 1 | Freeze monitoring |
| mask_out | input | 1 | Force pin inactive |
| temp_rd | input | 1 | Temperature-register read strobe |
| ovt_pin | output | 1 | Over-temperature alarm pin |

## Verification
The bench places samples exactly at the trip limit and the hysteresis limit. An off-by-one comparison would then trip or release one sample early. It also runs a negative-threshold case that an unsigned comparator would miss entirely. For each fault setting it breaks a hot run one sample short of the trip and checks that the alarm fires only after a full run. A counter that did not restart, or that used the wrong depth, would fire early or late. In interrupt mode it keeps the temperature hot after a read, to catch a design that re-latches at once. It also reads while idle, to catch a design that gets stuck waiting, and it combines a read with a cool sample in the same cycle. Stop, mask and the missing strobe are each shown to leave the observable alarm unchanged or merely hidden.

// File: rtl/ovt_pkg.sv
package ovt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALARM = 2'd1,
    ST_REARM = 2'd2
  } ovt_state_e;

  // consecutive hot samples required for each fault selector value
  function automatic int unsigned fault_need(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 6;
    endcase
  endfunction

  // level seen on the pin for a given logical alarm and polarity
  function automatic logic pin_level(input logic active, input logic high_true);
    return high_true ? active : ~active;
  endfunction

endpackage

// File: rtl/ovt_compare.sv
module ovt_compare #(
  parameter int TW         = 9,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic          samp_valid,
  input  logic          stop,
  input  logic [TW-1:0] samp_temp,
  input  logic [TW-1:0] lim_over,
  input  logic [TW-1:0] lim_hyst,
  output logic          ev_take,
  output logic          ev_hot,
  output logic          ev_cool
);

  logic above, below;

  generate
    if (SIGNED_CMP) begin : g_signed
      assign above = $signed(samp_temp) > $signed(lim_over);
      assign below = $signed(samp_temp) < $signed(lim_hyst);
    end else begin : g_unsigned
      assign above = samp_temp > lim_over;
      assign below = samp_temp < lim_hyst;
    end
  endgenerate

  assign ev_take = samp_valid & ~stop;
  assign ev_hot  = ev_take & above;
  assign ev_cool = ev_take & below;

endmodule

// File: rtl/ovt_fault_q.sv
module ovt_fault_q #(
  parameter int FQ_MAX = 6,
  localparam int CW    = $clog2(FQ_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_take,
  input  logic          ev_hot,
  input  logic [1:0]    fault_sel,
  output logic          ev_trip,
  output logic [CW-1:0] run_cnt
);

  logic [CW:0] need;
  logic [CW:0] run_next;

  assign need     = (CW+1)'(ovt_pkg::fault_need(fault_sel));
  assign run_next = {1'b0, run_cnt} + 1'b1;
  assign ev_trip  = ev_hot & (run_next >= need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (ev_take) begin
      if (!ev_hot)
        run_cnt <= '0;
      else if (run_cnt != CW'(FQ_MAX))
        run_cnt <= run_next[CW-1:0];
    end
  end

endmodule

// File: rtl/ovt_mode_fsm.sv
module ovt_mode_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  irq_mode,
  input  logic                  temp_rd,
  input  logic                  ev_trip,
  input  logic                  ev_cool,
  output ovt_pkg::ovt_state_e   st,
  output logic                  alarm_act
);
  import ovt_pkg::*;

  ovt_state_e st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (ev_trip) st_nx = ST_ALARM;
      ST_ALARM: begin
        if (irq_mode) begin
          if (temp_rd) st_nx = ST_REARM;
        end else if (ev_cool) begin
          st_nx = ST_IDLE;
        end
      end
      ST_REARM: if (ev_cool) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign alarm_act = (st == ST_ALARM);

endmodule

// File: rtl/ovt_pin_drv.sv
module ovt_pin_drv (
  input  logic alarm_act,
  input  logic mask_out,
  input  logic act_high,
  output logic ovt_pin
);

  assign ovt_pin = ovt_pkg::pin_level(alarm_act & ~mask_out, act_high);

endmodule

// File: rtl/ovt_alarm.sv
module ovt_alarm #(
  parameter int TW     = 9,
  parameter int FQ_MAX = 6,
  localparam int CW    = $clog2(FQ_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_valid,
  input  logic [TW-1:0] samp_temp,
  input  logic [TW-1:0] lim_over,
  input  logic [TW-1:0] lim_hyst,
  input  logic [1:0]    fault_sel,
  input  logic          irq_mode,
  input  logic          act_high,
  input  logic          stop,
  input  logic          mask_out,
  input  logic          temp_rd,
  output logic          ovt_pin
);

  // named internal events, observed by the bound checker
  logic                ev_take;
  logic                ev_hot;
  logic                ev_cool;
  logic                ev_trip;
  logic [CW-1:0]       run_cnt;
  logic                alarm_act;
  ovt_pkg::ovt_state_e st;

  ovt_compare #(.TW(TW), .SIGNED_CMP(1'b1)) u_cmp (
    .samp_valid (samp_valid),
    .stop       (stop),
    .samp_temp  (samp_temp),
    .lim_over   (lim_over),
    .lim_hyst   (lim_hyst),
    .ev_take    (ev_take),
    .ev_hot     (ev_hot),
    .ev_cool    (ev_cool)
  );

  ovt_fault_q #(.FQ_MAX(FQ_MAX)) u_fq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_take   (ev_take),
    .ev_hot    (ev_hot),
    .fault_sel (fault_sel),
    .ev_trip   (ev_trip),
    .run_cnt   (run_cnt)
  );

  ovt_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_mode  (irq_mode),
    .temp_rd   (temp_rd),
    .ev_trip   (ev_trip),
    .ev_cool   (ev_cool),
    .st        (st),
    .alarm_act (alarm_act)
  );

  ovt_pin_drv u_pin (
    .alarm_act (alarm_act),
    .mask_out  (mask_out),
    .act_high  (act_high),
    .ovt_pin   (ovt_pin)
  );

endmodule

// File: rtl/ovt_alarm_chk.sv
module ovt_alarm_chk #(
  parameter int CW = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stop,
  input logic                temp_rd,
  input logic                irq_mode,
  input logic                act_high,
  input logic                mask_out,
  input logic                ovt_pin,
  input logic                ev_cool,
  input logic                ev_trip,
  input logic                alarm_act,
  input logic [CW-1:0]       run_cnt,
  input ovt_pkg::ovt_state_e st
);
  import ovt_pkg::*;

  p_trip_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && ev_trip) |=> alarm_act);

  p_cmp_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode && alarm_act && ev_cool) |=> !alarm_act);

  p_cmp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode && alarm_act && !ev_cool) |=> alarm_act);

  p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && alarm_act && !temp_rd) |=> alarm_act);

  p_irq_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && alarm_act && temp_rd) |=> !alarm_act);

  p_rearm_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REARM && !ev_cool) |=> !alarm_act);

  p_polarity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_act && !mask_out) |-> (ovt_pin == act_high));

  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_out |-> (ovt_pin == !act_high));

  p_stop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> $stable(run_cnt));

  p_stop_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !temp_rd) |=> $stable(st));

endmodule

bind ovt_alarm ovt_alarm_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop      (stop),
  .temp_rd   (temp_rd),
  .irq_mode  (irq_mode),
  .act_high  (act_high),
  .mask_out  (mask_out),
  .ovt_pin   (ovt_pin),
  .ev_cool   (ev_cool),
  .ev_trip   (ev_trip),
  .alarm_act (alarm_act),
  .run_cnt   (run_cnt),
  .st        (st)
);

// File: tb/ovt_alarm_test.sv
`timescale 1ns/1ps
module ovt_alarm_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       samp_valid;
  logic [8:0] samp_temp;
  logic [8:0] lim_over;
  logic [8:0] lim_hyst;
  logic [1:0] fault_sel;
  logic       irq_mode;
  logic       act_high;
  logic       stop;
  logic       mask_out;
  logic       temp_rd;
  logic       ovt_pin;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ovt_alarm uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_valid (samp_valid),
    .samp_temp  (samp_temp),
    .lim_over   (lim_over),
    .lim_hyst   (lim_hyst),
    .fault_sel  (fault_sel),
    .irq_mode   (irq_mode),
    .act_high   (act_high),
    .stop       (stop),
    .mask_out   (mask_out),
    .temp_rd    (temp_rd),
    .ovt_pin    (ovt_pin)
  );

  // expected pin from a logical alarm state, restated from R6
  function automatic logic want_pin(input logic active);
    return (active == act_high);
  endfunction

  task automatic chk(input string req, input logic active_exp);
    logic exp_v;
    exp_v = want_pin(active_exp);
    checks++;
    if (ovt_pin !== exp_v) begin
      failures++;
      $display("FAIL %s: ovt_pin actual=%b expected=%b", req, ovt_pin, exp_v);
    end
  endtask

  task automatic defaults();
    samp_valid = 1'b0; samp_temp = 9'd0; temp_rd = 1'b0;
    lim_over = 9'd160; lim_hyst = 9'd150;
    fault_sel = 2'd0; irq_mode = 1'b0; act_high = 1'b0;
    stop = 1'b0; mask_out = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one valid sample, optionally together with a temperature read
  task automatic sample(input logic [8:0] t, input logic rd = 1'b0);
    samp_temp = t; samp_valid = 1'b1; temp_rd = rd;
    @(negedge clk);
    samp_valid = 1'b0; temp_rd = 1'b0;
  endtask

  task automatic rd_only();
    temp_rd = 1'b1;
    @(negedge clk);
    temp_rd = 1'b0;
  endtask

  task automatic t_reset();
    defaults(); do_reset();
    chk("R10 reset inactive", 1'b0);
  endtask

  task automatic t_limit_edge();
    defaults(); do_reset();
    sample(9'd160); chk("R1 equal to limit not hot", 1'b0);
    sample(9'd161); chk("R1 above limit trips", 1'b1);
  endtask

  task automatic t_cmp_hyst();
    defaults(); do_reset();
    sample(9'd170); chk("R3 trip", 1'b1);
    sample(9'd150); chk("R3 equal hyst holds", 1'b1);
    rd_only();      chk("R3 read ignored", 1'b1);
    sample(9'd155); chk("R3 between holds", 1'b1);
    sample(9'd149); chk("R3 below hyst releases", 1'b0);
  endtask

  task automatic t_signed();
    defaults(); lim_over = 9'h1EC; lim_hyst = 9'h1C4; do_reset();
    sample(9'h1EC); chk("R1 signed equal not hot", 1'b0);
    sample(9'h00A); chk("R1 signed positive over negative limit", 1'b1);
    sample(9'h1C8); chk("R1 signed between holds", 1'b1);
    sample(9'h1B0); chk("R1 signed below hyst releases", 1'b0);
  endtask

  task automatic t_fault(input logic [1:0] sel, input int need);
    defaults(); fault_sel = sel; do_reset();
    for (int i = 0; i < need - 1; i++) sample(9'd170);
    chk($sformatf("R2 sel=%0d short run", sel), 1'b0);
    sample(9'd155);
    for (int i = 0; i < need - 1; i++) sample(9'd170);
    chk($sformatf("R2 sel=%0d restarted run", sel), 1'b0);
    sample(9'd170);
    chk($sformatf("R2 sel=%0d full run trips", sel), 1'b1);
  endtask

  task automatic t_irq();
    defaults(); irq_mode = 1'b1; do_reset();
    sample(9'd170); chk("R4 trip", 1'b1);
    sample(9'd100); chk("R4 cool does not release", 1'b1);
    rd_only();      chk("R4 read releases", 1'b0);
    sample(9'd170); chk("R5 hot after read stays quiet", 1'b0);
    sample(9'd155); chk("R5 between stays quiet", 1'b0);
    sample(9'd140); chk("R5 cool re-arms quietly", 1'b0);
    sample(9'd170); chk("R5 trips again after re-arm", 1'b1);
  endtask

  task automatic t_irq_read_corner();
    defaults(); irq_mode = 1'b1; do_reset();
    rd_only();
    sample(9'd170); chk("R11 idle read no effect", 1'b1);
    sample(9'd100, 1'b1); chk("R11 read with cool releases", 1'b0);
    sample(9'd170); chk("R11 same-cycle cool not re-arming", 1'b0);
  endtask

  task automatic t_polarity();
    defaults(); act_high = 1'b1; do_reset();
    chk("R6 active-high idle low", 1'b0);
    sample(9'd170); chk("R6 active-high asserted", 1'b1);
  endtask

  task automatic t_mask();
    defaults(); do_reset();
    sample(9'd170);
    mask_out = 1'b1; @(negedge clk);
    chk("R7 masked pin inactive", 1'b0);
    mask_out = 1'b0; @(negedge clk);
    chk("R7 unmask shows held alarm", 1'b1);
  endtask

  task automatic t_stop();
    defaults(); fault_sel = 2'd1; do_reset();
    sample(9'd170);
    stop = 1'b1; sample(9'd170); sample(9'd170); stop = 1'b0;
    chk("R8 stopped samples not counted", 1'b0);
    sample(9'd170); chk("R8 count kept across stop", 1'b1);
    stop = 1'b1; sample(9'd100); stop = 1'b0;
    chk("R8 stopped cool sample ignored", 1'b1);
  endtask

  task automatic t_novalid();
    defaults(); do_reset();
    samp_temp = 9'd200;
    repeat (8) @(negedge clk);
    chk("R9 no strobe no trip", 1'b0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    defaults();
    t_reset();
    t_limit_edge();
    t_cmp_hyst();
    t_signed();
    t_fault(2'd0, 1);
    t_fault(2'd1, 2);
    t_fault(2'd2, 4);
    t_fault(2'd3, 6);
    t_irq();
    t_irq_read_corner();
    t_polarity();
    t_mask();
    t_stop();
    t_novalid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule